// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular list of transmit descriptors kept in word-wide memory. When the descriptor at the current ring index belongs to the controller, the engine reads the buffer address and byte count and streams the buffer one byte at a time over a valid/ready output. It then writes the completion status back into both descriptor words, returns ownership to the host and raises a sticky interrupt flag. It then goes straight on to the next index.

The host gives one configuration word, the ring pointer. Its top three bits hold log2 of the entry count and its low bits hold the ring's byte base. The host queues a single-buffer frame by writing the flag byte 0x83, which sets owner, start-of-frame and end-of-frame together. A demand pulse makes the engine look at the current descriptor at once. Without a demand, an idle engine looks again each time its poll interval runs out. The frame outcome arrives on sideband inputs: the retry count and four error causes. A buffer underflow halts the engine until the host gives a restart pulse.

Memory is reached through a plain request port. Reads return data on `mem_rdata` one cycle after the request. Writes take effect at the request edge.

Top module: `txr_engine`

## Requirements
- R1: The ring holds 2^L entries, where L is `ring_ptr[31:29]` capped at MAX_LOG2. The current index counts up and wraps to 0 after entry 2^L-1.
- R2: Entry i sits at byte address `ring_ptr[23:0]` + 8*i, which is 8-byte aligned. Word 0 holds the buffer byte address in bits 23:0 and flags in bits 31:24. Bit 31 is the owner bit (1 = controller) and bits 25/24 mark start and end of frame. Word 1 holds the negated byte count in bits 31:16 and status in bits 15:0.
- R3: If the descriptor at the current index has owner bit 0, the engine sends no byte, writes no memory and keeps its index.
- R4: A `tx_demand` pulse starts a descriptor read within one cycle while the engine is idle. Without a demand, an idle engine reads the descriptor again every POLL_CYCLES cycles.
- R5: The engine sends exactly (-word1[31:16]) mod 2^16 bytes, in increasing byte address from the buffer address. The byte at address a is lane a mod 4 (bits 8*(a mod 4)+7 : 8*(a mod 4)) of memory word a/4. `tx_last` is high with the final byte only.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R7: On completion, word 0 is written back with bit 31 cleared and with bit 30 set if any error input was high. Bit 28 is set if `tx_retries` >= 2 with no error, and bit 27 is set if `tx_retries` == 1 with no error. Bits 29 and 26:0 are kept.
- R8: On completion, word 1 keeps bits 31:16. Its bits 10, 11, 12 and 14 take excess-retry abort, lost carrier, late collision and underflow. All other low bits are zero. The sideband inputs are sampled with the final byte, or at the word-1 read for a zero count.
- R9: Each completion sets `tx_int`. It stays set until an `int_ack` pulse with no completion in the same cycle.
- R10: After a completion with underflow, `tx_halted` is high and no descriptor is read. A `tx_restart` pulse clears the halt and reads the current index at once.
- R11: A byte count field of zero sends no byte but still writes back both words and sets `tx_int`.
- R12: After a completion without underflow, the engine advances the index and reads the next descriptor without waiting for a demand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ring_ptr | input | 32 | Ring log2 size [31:29] and byte base [23:0] |
| tx_demand | input | 1 | Poll-now pulse |
| tx_restart | input | 1 | Leave the halted state |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 22 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_last | output | 1 | Final byte of frame |
| tx_retries | input | 2 | Retries used by this frame |
| tx_err_abort | input | 1 | Excess-retry abort |
| tx_err_nocarrier | input | 1 | Carrier lost |
| tx_err_late | input | 1 | Late collision |
| tx_err_underflow | input | 1 | Buffer underflow |
| tx_int | output | 1 | Sticky completion flag |
| int_ack | input | 1 | Clears the completion flag |
| tx_halted | output | 1 | Engine stopped after underflow |
| cur_index | output | 7 | Current ring index |

## Verification
The hardest condition to reach is an engine that sits idle on a host-owned entry and later wakes from its poll timer alone, with no demand. The stimulus creates it by leaving the entry after the last queued frame empty, so the engine parks there by itself. A late demand is shown to change nothing, and the descriptor is then written with no demand at all. The halted state is reached in the same way: an underflow frame is followed by a controller-owned entry that must stay untouched until the restart pulse. Ring wrap is exercised after a reset that sets a four-entry ring, with a fifth frame placed back in entry 0.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_RD0, S_W0, S_W1, S_FETCH, S_FWAIT, S_STREAM, S_WB1, S_WB0, S_HALT
    } txr_state_e;

    typedef struct packed {
        logic [1:0] retries;
        logic       abort;
        logic       nocarrier;
        logic       late;
        logic       underflow;
    } txr_outcome_t;

    localparam int OWN_BIT   = 31;
    localparam int ERR_BIT   = 30;
    localparam int MULTI_BIT = 28;
    localparam int ONCE_BIT  = 27;

    localparam int ST_ABORT  = 10;
    localparam int ST_CARR   = 11;
    localparam int ST_LATE   = 12;
    localparam int ST_UFLOW  = 14;

endpackage

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
    parameter int POLL_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic fire
);
    localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(POLL_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || fire) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/txr_ring_addr.sv
module txr_ring_addr #(
    parameter int BUF_AW   = 24,
    parameter int MAX_LOG2 = 7
) (
    input  logic [31:0]          ring_ptr,
    input  logic [MAX_LOG2-1:0]  idx,
    output logic [BUF_AW-3:0]    desc_addr,
    output logic [MAX_LOG2-1:0]  idx_next
);
    localparam int IDX_W = MAX_LOG2;
    localparam int MW    = BUF_AW - 2;

    logic [2:0]       lg;
    logic [2:0]       eff;
    logic [IDX_W:0]   span;
    logic [IDX_W-1:0] mask;

    always_comb begin
        lg   = ring_ptr[31:29];
        eff  = (int'(lg) > MAX_LOG2) ? 3'(MAX_LOG2) : lg;
        span = (IDX_W+1)'(1) << eff;
        mask = IDX_W'(span - 1'b1);
        idx_next  = (idx + 1'b1) & mask;
        desc_addr = ring_ptr[BUF_AW-1:2] + MW'({idx, 1'b0});
    end
endmodule

// File: rtl/txr_wb_pack.sv
module txr_wb_pack
    import txr_pkg::*;
(
    input  logic [31:0]  w0_in,
    input  logic [15:0]  cnt_field,
    input  txr_outcome_t outc,
    output logic [31:0]  wb0,
    output logic [31:0]  wb1
);
    logic any_err;

    always_comb begin
        any_err = outc.abort | outc.nocarrier | outc.late | outc.underflow;
        wb0 = w0_in;
        wb0[OWN_BIT]   = 1'b0;
        wb0[ERR_BIT]   = any_err;
        wb0[MULTI_BIT] = !any_err && (outc.retries >= 2'd2);
        wb0[ONCE_BIT]  = !any_err && (outc.retries == 2'd1);
        wb1 = {cnt_field, 16'h0000};
        wb1[ST_ABORT] = outc.abort;
        wb1[ST_CARR]  = outc.nocarrier;
        wb1[ST_LATE]  = outc.late;
        wb1[ST_UFLOW] = outc.underflow;
    end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
    import txr_pkg::*;
#(
    parameter int BUF_AW      = 24,
    parameter int MAX_LOG2    = 7,
    parameter int POLL_CYCLES = 200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          ring_ptr,
    input  logic                 tx_demand,
    input  logic                 tx_restart,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [BUF_AW-3:0]    mem_addr,
    output logic [31:0]          mem_wdata,
    input  logic [31:0]          mem_rdata,
    output logic [7:0]           tx_data,
    output logic                 tx_valid,
    input  logic                 tx_ready,
    output logic                 tx_last,
    input  logic [1:0]           tx_retries,
    input  logic                 tx_err_abort,
    input  logic                 tx_err_nocarrier,
    input  logic                 tx_err_late,
    input  logic                 tx_err_underflow,
    output logic                 tx_int,
    input  logic                 int_ack,
    output logic                 tx_halted,
    output logic [MAX_LOG2-1:0]  cur_index
);
    localparam int MW    = BUF_AW - 2;
    localparam int IDX_W = MAX_LOG2;
    localparam int LEN_W = 16;

    typedef struct packed {
        txr_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [31:0]       w0;
        logic [LEN_W-1:0]  cnt_field;
        logic [LEN_W-1:0]  remain;
        logic [BUF_AW-1:0] baddr;
        logic [31:0]       word;
        txr_outcome_t      outc;
        logic              irq;
    } regs_t;

    regs_t r_q, r_d;

    logic [MW-1:0]    desc_addr;
    logic [IDX_W-1:0] idx_next;
    logic             poll_fire;
    logic [31:0]      wb0, wb1;
    txr_outcome_t     side;
    logic [31:0]      lane_shift;

    txr_ring_addr #(.BUF_AW(BUF_AW), .MAX_LOG2(MAX_LOG2)) addr_i (
        .ring_ptr  (ring_ptr),
        .idx       (r_q.idx),
        .desc_addr (desc_addr),
        .idx_next  (idx_next)
    );

    txr_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) poll_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.state == S_IDLE),
        .fire  (poll_fire)
    );

    txr_wb_pack pack_i (
        .w0_in     (r_q.w0),
        .cnt_field (r_q.cnt_field),
        .outc      (r_q.outc),
        .wb0       (wb0),
        .wb1       (wb1)
    );

    always_comb begin
        side.retries   = tx_retries;
        side.abort     = tx_err_abort;
        side.nocarrier = tx_err_nocarrier;
        side.late      = tx_err_late;
        side.underflow = tx_err_underflow;
    end

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        tx_valid  = 1'b0;
        if (int_ack) begin
            r_d.irq = 1'b0;
        end
        case (r_q.state)
            S_IDLE: begin
                if (tx_demand || poll_fire) begin
                    r_d.state = S_RD0;
                end
            end
            S_RD0: begin
                mem_req   = 1'b1;
                r_d.state = S_W0;
            end
            S_W0: begin
                if (!mem_rdata[OWN_BIT]) begin
                    r_d.state = S_IDLE;
                end else begin
                    r_d.w0    = mem_rdata;
                    mem_req   = 1'b1;
                    mem_addr  = desc_addr + MW'(1);
                    r_d.state = S_W1;
                end
            end
            S_W1: begin
                r_d.cnt_field = mem_rdata[31:16];
                r_d.remain    = LEN_W'(~mem_rdata[31:16] + 16'd1);
                r_d.baddr     = r_q.w0[BUF_AW-1:0];
                if (mem_rdata[31:16] == 16'd0) begin
                    r_d.outc  = side;
                    r_d.state = S_WB1;
                end else begin
                    r_d.state = S_FETCH;
                end
            end
            S_FETCH: begin
                mem_req   = 1'b1;
                mem_addr  = r_q.baddr[BUF_AW-1:2];
                r_d.state = S_FWAIT;
            end
            S_FWAIT: begin
                r_d.word  = mem_rdata;
                r_d.state = S_STREAM;
            end
            S_STREAM: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    r_d.remain = r_q.remain - 1'b1;
                    r_d.baddr  = r_q.baddr + 1'b1;
                    if (r_q.remain == LEN_W'(1)) begin
                        r_d.outc  = side;
                        r_d.state = S_WB1;
                    end else if (r_q.baddr[1:0] == 2'b11) begin
                        r_d.state = S_FETCH;
                    end
                end
            end
            S_WB1: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + MW'(1);
                mem_wdata = wb1;
                r_d.state = S_WB0;
            end
            S_WB0: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wb0;
                r_d.irq   = 1'b1;
                r_d.idx   = idx_next;
                r_d.state = r_q.outc.underflow ? S_HALT : S_RD0;
            end
            S_HALT: begin
                if (tx_restart) begin
                    r_d.state = S_RD0;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, outc: '0, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        lane_shift = r_q.word >> {r_q.baddr[1:0], 3'b000};
        tx_data    = lane_shift[7:0];
        tx_last    = (r_q.state == S_STREAM) && (r_q.remain == LEN_W'(1));
        tx_int     = r_q.irq;
        tx_halted  = (r_q.state == S_HALT);
        cur_index  = r_q.idx;
    end
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
    parameter int MW       = 22,
    parameter int MAX_LOG2 = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic [31:0]         ring_ptr,
    input logic                tx_restart,
    input logic                mem_req,
    input logic                mem_we,
    input logic [MW-1:0]       mem_addr,
    input logic [7:0]          tx_data,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic                tx_last,
    input logic                tx_int,
    input logic                int_ack,
    input logic                tx_halted,
    input logic [MAX_LOG2-1:0] cur_index
);
    logic [2:0] lg_c;
    logic [2:0] eff_c;
    logic [MAX_LOG2-1:0] above;

    always_comb begin
        lg_c  = ring_ptr[31:29];
        eff_c = (int'(lg_c) > MAX_LOG2) ? 3'(MAX_LOG2) : lg_c;
        above = cur_index >> eff_c;
    end

    assert_index_in_ring_R1: assert property (@(posedge clk) disable iff (!rst_n)
        above == '0);

    assert_hold_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    assert_no_mem_while_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_req);

    assert_sticky_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_int && !int_ack |=> tx_int);

    assert_int_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_int) |-> $past(mem_req && mem_we));

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_halted && !tx_restart |=> !tx_valid && !mem_req);

    assert_advance_on_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_index) |-> $past(mem_req && mem_we));

endmodule

bind txr_engine txr_engine_chk #(.MW(MW), .MAX_LOG2(MAX_LOG2)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_ptr   (ring_ptr),
    .tx_restart (tx_restart),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_last    (tx_last),
    .tx_int     (tx_int),
    .int_ack    (int_ack),
    .tx_halted  (tx_halted),
    .cur_index  (cur_index)
);

// File: tb/txr_engine_tb_top.sv
module txr_engine_tb_top;

    localparam int RB    = 32'h40;
    localparam int MEMW  = 2048;
    localparam int POLL  = 200;

    typedef struct packed {
        logic [11:0] len;
        logic [7:0]  off;
        logic [1:0]  retr;
        logic        ab;
        logic        ca;
        logic        la;
        logic        stall;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{12'd5,  8'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{12'd1,  8'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{12'd13, 8'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1},
        '{12'd60, 8'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1},
        '{12'd7,  8'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{12'd9,  8'd3, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ring_ptr = {3'd4, 5'd0, 24'h000100};
    logic        tx_demand = 1'b0;
    logic        tx_restart = 1'b0;
    logic        mem_req, mem_we;
    logic [21:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b1;
    logic [1:0]  tx_retries = '0;
    logic        tx_err_abort = 1'b0, tx_err_nocarrier = 1'b0;
    logic        tx_err_late = 1'b0, tx_err_underflow = 1'b0;
    logic        tx_int;
    logic        int_ack = 1'b0;
    logic        tx_halted;
    logic [6:0]  cur_index;

    logic [31:0] mem [MEMW];
    logic [7:0]  cap_byte [4096];
    logic        cap_last [4096];
    int          cap_time [4096];
    int          rx_cnt = 0;
    int          cyc = 0;
    logic        stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    txr_engine dut_i (
        .clk(clk), .rst_n(rst_n), .ring_ptr(ring_ptr),
        .tx_demand(tx_demand), .tx_restart(tx_restart),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_last(tx_last), .tx_retries(tx_retries),
        .tx_err_abort(tx_err_abort), .tx_err_nocarrier(tx_err_nocarrier),
        .tx_err_late(tx_err_late), .tx_err_underflow(tx_err_underflow),
        .tx_int(tx_int), .int_ack(int_ack), .tx_halted(tx_halted),
        .cur_index(cur_index)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req) begin
            if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[10:0]];
        end
    end

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tx_ready = stall_mode ? lfsr[0] : 1'b1;
        if (rst_n && tx_valid && tx_ready) begin
            cap_byte[rx_cnt] = tx_data;
            cap_last[rx_cnt] = tx_last;
            cap_time[rx_cnt] = cyc;
            rx_cnt = rx_cnt + 1;
        end
    end

    function automatic logic [7:0] pat(int a);
        return 8'(a) ^ 8'h5A ^ 8'(a >> 8);
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic put_desc(int idx, int baddr, int len);
        @(negedge clk);
        mem[RB + 2*idx + 1] = {16'(0 - len), 16'h0000};
        mem[RB + 2*idx]     = {8'h83, 24'(baddr)};
    endtask

    task automatic fill_buf(int baddr, int len);
        for (int a = baddr; a < baddr + len; a++) begin
            mem[a >> 2][8*(a % 4) +: 8] = pat(a);
        end
    endtask

    task automatic pulse_demand(output int at);
        @(negedge clk);
        tx_demand = 1'b1;
        at = cyc;
        @(negedge clk);
        tx_demand = 1'b0;
    endtask

    task automatic wait_done(int idx, string req, output bit ok);
        ok = 0;
        for (int t = 0; t < 6000; t++) begin
            @(negedge clk);
            if (!mem[RB + 2*idx][31]) begin
                ok = 1;
                break;
            end
        end
        check(ok, req, 0, 1);
    endtask

    task automatic ack_int();
        @(negedge clk);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
        @(negedge clk);
        check(tx_int == 1'b0, "R9 ack clears", tx_int, 0);
    endtask

    task automatic set_side(logic [1:0] rt, logic ab, logic ca, logic la, logic uf);
        tx_retries = rt; tx_err_abort = ab; tx_err_nocarrier = ca;
        tx_err_late = la; tx_err_underflow = uf;
    endtask

    task automatic verify_frame(int idx, int baddr, int len, int start,
                                logic [1:0] rt, logic ab, logic ca, logic la, logic uf);
        bit good = 1;
        logic err;
        logic [31:0] e0, e1;
        check(rx_cnt - start == len, "R5 byte count", rx_cnt - start, len);
        for (int i = 0; i < len && i < rx_cnt - start; i++) begin
            if (cap_byte[start+i] != pat(baddr + i)) good = 0;
            if (cap_last[start+i] != (i == len - 1)) good = 0;
        end
        check(good, "R5 bytes and last flag", good, 1);
        err = ab | ca | la | uf;
        e0 = {1'b0, err, 1'b0, !err && rt >= 2'd2, !err && rt == 2'd1, 3'b011, 24'(baddr)};
        e1 = {16'(0 - len), 1'b0, uf, 1'b0, la, ca, ab, 10'b0};
        check(mem[RB + 2*idx] == e0, "R7 word0 writeback", mem[RB + 2*idx], e0);
        check(mem[RB + 2*idx + 1] == e1, "R8 word1 writeback", mem[RB + 2*idx + 1], e1);
        check(tx_int == 1'b1, "R9 int set", tx_int, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit ok;
        int dat;
        int start;
        int base;
        for (int i = 0; i < MEMW; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(tx_valid == 0 && mem_req == 0, "R3 reset quiet", {tx_valid, mem_req}, 0);
        check(tx_int == 0 && tx_halted == 0, "R9 reset flags", {tx_int, tx_halted}, 0);
        check(cur_index == 0, "R1 reset index", cur_index, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table of frames on entries 0..5, each queued with a demand pulse
        for (int k = 0; k < 6; k++) begin
            base = 32'h400 + k * 32'h80 + int'(VECS[k].off);
            stall_mode = VECS[k].stall;
            set_side(VECS[k].retr, VECS[k].ab, VECS[k].ca, VECS[k].la, 1'b0);
            fill_buf(base, int'(VECS[k].len));
            start = rx_cnt;
            put_desc(k, base, int'(VECS[k].len));
            pulse_demand(dat);
            wait_done(k, "R2 descriptor completes", ok);
            repeat (2) @(negedge clk);
            verify_frame(k, base, int'(VECS[k].len), start, VECS[k].retr,
                         VECS[k].ab, VECS[k].ca, VECS[k].la, 1'b0);
            if (!VECS[k].stall && rx_cnt > start)
                check(cap_time[start] - dat <= 8, "R4 demand latency", cap_time[start] - dat, 8);
            check(cur_index == 7'(k + 1), "R12 index advances", cur_index, k + 1);
            ack_int();
        end
        stall_mode = 1'b0;
        set_side(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R3: entry 6 is host-owned; demand and poll must change nothing
        start = rx_cnt;
        pulse_demand(dat);
        repeat (2 * POLL + 20) @(negedge clk);
        check(rx_cnt == start, "R3 no bytes when host-owned", rx_cnt - start, 0);
        check(cur_index == 7'd6, "R3 index kept", cur_index, 6);
        check(mem[RB + 12] == 0 && mem[RB + 13] == 0, "R3 no writeback", mem[RB + 12], 0);
        check(tx_int == 0, "R3 no interrupt", tx_int, 0);

        // R4: poll timer alone picks up entry 6
        base = 32'h700;
        fill_buf(base, 6);
        start = rx_cnt;
        put_desc(6, base, 6);
        wait_done(6, "R4 poll wakes engine", ok);
        repeat (2) @(negedge clk);
        verify_frame(6, base, 6, start, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        ack_int();

        // R11: zero byte count
        start = rx_cnt;
        put_desc(7, 32'h780, 0);
        pulse_demand(dat);
        wait_done(7, "R11 zero length completes", ok);
        repeat (2) @(negedge clk);
        verify_frame(7, 32'h780, 0, start, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        ack_int();

        // R10: underflow halts until restart
        base = 32'h7A1;
        fill_buf(base, 4);
        set_side(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        start = rx_cnt;
        put_desc(8, base, 4);
        pulse_demand(dat);
        wait_done(8, "R10 underflow frame completes", ok);
        repeat (2) @(negedge clk);
        verify_frame(8, base, 4, start, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
        check(tx_halted == 1, "R10 halted", tx_halted, 1);
        ack_int();
        set_side(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        base = 32'h7C0;
        fill_buf(base, 3);
        start = rx_cnt;
        put_desc(9, base, 3);
        pulse_demand(dat);
        repeat (2 * POLL + 20) @(negedge clk);
        check(rx_cnt == start, "R10 no bytes while halted", rx_cnt - start, 0);
        check(mem[RB + 18][31] == 1'b1, "R10 descriptor untouched", mem[RB + 18][31], 1);
        check(cur_index == 7'd9, "R10 index held", cur_index, 9);
        @(negedge clk);
        tx_restart = 1'b1;
        @(negedge clk);
        tx_restart = 1'b0;
        wait_done(9, "R10 restart resumes", ok);
        repeat (2) @(negedge clk);
        verify_frame(9, base, 3, start, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(tx_halted == 0, "R10 halt cleared", tx_halted, 0);
        ack_int();

        // R1: four-entry ring wraps back to entry 0
        @(negedge clk);
        rst_n = 1'b0;
        ring_ptr = {3'd2, 5'd0, 24'h000100};
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            base = 32'h1000 + k * 32'h20;
            fill_buf(base, 2 + k);
            start = rx_cnt;
            put_desc(k % 4, base, 2 + k);
            pulse_demand(dat);
            wait_done(k % 4, "R1 ring entry completes", ok);
            repeat (2) @(negedge clk);
            verify_frame(k % 4, base, 2 + k, start, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
            check(cur_index == 7'((k + 1) % 4), "R1 wrap index", cur_index, (k + 1) % 4);
            ack_int();
        end
        finish_run();
    end
endmodule